// File: doc/BRIEF.md
# Three-Input Lookup Logic Cell

This block is one programmable cell of a fine-grained reconfigurable fabric. Three input selectors each pick one wire from a group of candidate neighbour wires. The three picked bits address an eight-entry truth table. The table output can go straight to the cell result, or it can pass through a level-sensitive storage latch. The latch takes its enable from one of two clock inputs. It can be forced to a programmed value, and its stored value can be fed back into the table so that asynchronous state-holding functions can be built.

Three output selectors each drive one neighbour output. Each selector sends out either the cell result or one of the picked input wires unchanged, so the cell can also serve as a routing feed-through. The cell result also goes onto segmented channel wires. Each channel wire is modelled as a data bit plus an enable bit, so no net in the block is ever high-impedance. All settings come from one static parallel configuration word.

Top module: `lut3_cell`

## Requirements
- R1: Configuration word bit fields, from LSB upwards:
  - bits [1:0], [3:2] and [5:4] are the selectors for table inputs A, B and C;
  - bits [13:6] are the truth table;
  - bit 14 bypasses the latch;
  - bit 15 picks the latch clock;
  - bit 16 is the forced value;
  - bit 17 enables feedback;
  - bits [19:18], [21:20] and [23:22] are the output selector codes for outputs 0, 1 and 2;
  - bits [25:24] are the channel driver enables.

  Table input k takes the value of `cand_i[4*k + s]`, where s is that input's 2-bit selector.
- R2: The table output is truth bit number {C,B,A}, with A as the least significant address bit.
- R3: With the bypass bit set, the cell result equals the table output at once, whatever the clocks are doing.
- R4: With the clock-pick bit at 0 the latch is enabled by `clk_a`, and with it at 1 by `clk_b`. The clock that is not picked has no effect.
- R5: While the picked clock is high and `init_i` is low, the stored value follows the table output.
- R6: While the picked clock is low, changes on candidate wires do not alter the stored value.
- R7: While `init_i` is high, the stored value equals the forced-value bit regardless of clocks and data. After `init_i` falls while the clock is low, that value is held.
- R8: With feedback enabled, table input C is taken from the stored value instead of its selected wire. A table programmed as a majority of {A, B, stored} then holds its state when A and B differ.
- R9: Output selector code 0 sends the cell result out. Codes 1, 2 and 3 send out the selected wire of input A, B or C, taken before any feedback substitution.
- R10: Channel enable k equals enable bit k. Channel data k equals the cell result when enabled and 0 when disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First latch clock |
| clk_b | input | 1 | Second latch clock |
| init_i | input | 1 | Active-high force of the stored value |
| cfg_i | input | 26 | Static configuration word |
| cand_i | input | 12 | Candidate wires, four per table input |
| nbr_o | output | 3 | Neighbour outputs from the output selectors |
| seg_d_o | output | 2 | Channel driver data |
| seg_oe_o | output | 2 | Channel driver enables |

## Verification
A wrong stored value shows up in the same phase on every neighbour output and enabled channel that selects the result. A latch that fails to close shows up at the first candidate change in the low phase. One that fails to open shows up half a cycle later, when the high phase begins. Feedback faults appear only as a lost or falsely changed state when A and B disagree, so the bench walks the majority table through both hold cases. Selector or routing faults are exposed at once by one-hot candidate patterns and by feed-through codes that differ from the cell result.

// File: rtl/lut3_pkg.sv
`timescale 1ns/100ps
package lut3_pkg;
    localparam int N_IN   = 3;
    localparam int N_CAND = 4;
    localparam int SEL_W  = $clog2(N_CAND);
    localparam int TT_W   = 1 << N_IN;
    localparam int N_OUT  = 3;
    localparam int N_SEG  = 2;
    localparam int OSEL_W = $clog2(N_IN + 1);

    typedef enum logic [OSEL_W-1:0] {
        OM_RESULT = 2'd0,
        OM_PASS_A = 2'd1,
        OM_PASS_B = 2'd2,
        OM_PASS_C = 2'd3
    } omux_e;

    // Field order fixes the bit positions of the configuration word.
    typedef struct packed {
        logic [N_SEG-1:0]             seg_en;
        logic [N_OUT-1:0][OSEL_W-1:0] out_sel;
        logic                         fb_on;
        logic                         init_val;
        logic                         clk_b_sel;
        logic                         bypass;
        logic [TT_W-1:0]              truth;
        logic [N_IN-1:0][SEL_W-1:0]   in_sel;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic tt_lookup(input logic [TT_W-1:0] tt, input logic [N_IN-1:0] idx);
        return tt[idx];
    endfunction
endpackage

// File: rtl/lut3_insel.sv
`timescale 1ns/100ps
module lut3_insel #(
    parameter int N_CAND = 4,
    parameter int SEL_W  = 2
) (
    input  logic [N_CAND-1:0] cand_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              pick_o
);
    assign pick_o = cand_i[sel_i];
endmodule

// File: rtl/lut3_table.sv
`timescale 1ns/100ps
module lut3_table
    import lut3_pkg::*;
(
    input  logic [TT_W-1:0] truth_i,
    input  logic [N_IN-1:0] idx_i,
    output logic            y_o
);
    assign y_o = tt_lookup(truth_i, idx_i);
endmodule

// File: rtl/lut3_store.sv
`timescale 1ns/100ps
module lut3_store (
    input  logic clk_a,
    input  logic clk_b,
    input  logic clk_b_sel,
    input  logic init_i,
    input  logic init_val,
    input  logic d_i,
    output logic q_o
);
    logic gate;
    assign gate = clk_b_sel ? clk_b : clk_a;

    always_latch begin
        if (init_i)
            q_o <= init_val;
        else if (gate)
            q_o <= d_i;
    end

    // R7: forced value wins over clock and data
    assert_init_force_R7: assert property (@(posedge clk_a)
        init_i |-> (q_o == init_val));

    // R5: open latch tracks the table
    assert_transparent_R5: assert property (@(posedge clk_a) disable iff (init_i)
        (clk_b_sel && clk_b) |-> (q_o == d_i));

    // R6: closed latch keeps its value across a sampling period
    assert_hold_R6: assert property (@(posedge clk_a) disable iff (init_i)
        (clk_b_sel && !clk_b && $past(clk_b_sel) && !$past(clk_b) && !$past(init_i))
        |-> $stable(q_o));
endmodule

// File: rtl/lut3_drive.sv
`timescale 1ns/100ps
module lut3_drive
    import lut3_pkg::*;
(
    input  logic                         clk_a,
    input  logic                         init_i,
    input  logic                         result_i,
    input  logic [N_IN-1:0]              wire_i,
    input  logic [N_OUT-1:0][OSEL_W-1:0] osel_i,
    input  logic [N_SEG-1:0]             seg_en_i,
    output logic [N_OUT-1:0]             nbr_o,
    output logic [N_SEG-1:0]             seg_d_o,
    output logic [N_SEG-1:0]             seg_oe_o
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_omux
        logic pick;
        always_comb begin
            case (omux_e'(osel_i[j]))
                OM_PASS_A: pick = wire_i[0];
                OM_PASS_B: pick = wire_i[1];
                OM_PASS_C: pick = wire_i[2];
                default:   pick = result_i;
            endcase
        end
        assign nbr_o[j] = pick;
    end

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        assign seg_oe_o[k] = seg_en_i[k];
        assign seg_d_o[k]  = seg_en_i[k] & result_i;

        // R10: a disabled driver carries no data
        assert_seg_quiet_R10: assert property (@(posedge clk_a) disable iff (init_i)
            !seg_oe_o[k] |-> !seg_d_o[k]);
    end
endmodule

// File: rtl/lut3_cell.sv
`timescale 1ns/100ps
module lut3_cell
    import lut3_pkg::*;
(
    input  logic                     clk_a,
    input  logic                     clk_b,
    input  logic                     init_i,
    input  logic [CFG_W-1:0]         cfg_i,
    input  logic [N_IN*N_CAND-1:0]   cand_i,
    output logic [N_OUT-1:0]         nbr_o,
    output logic [N_SEG-1:0]         seg_d_o,
    output logic [N_SEG-1:0]         seg_oe_o
);
    cell_cfg_t       cfg;
    logic [N_IN-1:0] picked;
    logic [N_IN-1:0] tab_in;
    logic            tab_y;
    logic            stored;
    logic            result;

    assign cfg = cell_cfg_t'(cfg_i);

    for (genvar k = 0; k < N_IN; k++) begin : g_in
        lut3_insel #(.N_CAND(N_CAND), .SEL_W(SEL_W)) u_sel (
            .cand_i (cand_i[k*N_CAND +: N_CAND]),
            .sel_i  (cfg.in_sel[k]),
            .pick_o (picked[k])
        );
    end

    // Feedback replaces the most significant table input.
    always_comb begin
        tab_in = picked;
        if (cfg.fb_on)
            tab_in[N_IN-1] = stored;
    end

    lut3_table u_tab (
        .truth_i (cfg.truth),
        .idx_i   (tab_in),
        .y_o     (tab_y)
    );

    lut3_store u_store (
        .clk_a     (clk_a),
        .clk_b     (clk_b),
        .clk_b_sel (cfg.clk_b_sel),
        .init_i    (init_i),
        .init_val  (cfg.init_val),
        .d_i       (tab_y),
        .q_o       (stored)
    );

    assign result = cfg.bypass ? tab_y : stored;

    lut3_drive u_drv (
        .clk_a    (clk_a),
        .init_i   (init_i),
        .result_i (result),
        .wire_i   (picked),
        .osel_i   (cfg.out_sel),
        .seg_en_i (cfg.seg_en),
        .nbr_o    (nbr_o),
        .seg_d_o  (seg_d_o),
        .seg_oe_o (seg_oe_o)
    );

    // R3: bypassed result is the truth-table entry addressed by the table inputs
    assert_bypass_table_R3: assert property (@(posedge clk_a) disable iff (init_i)
        cfg.bypass |-> (result == cfg.truth[tab_in]));

    // R9: feed-through codes present the picked wire
    for (genvar j = 0; j < N_OUT; j++) begin : g_chk
        assert_pass_through_R9: assert property (@(posedge clk_a) disable iff (init_i)
            (cfg.out_sel[j] != OM_RESULT) |-> (nbr_o[j] == picked[cfg.out_sel[j] - 2'd1]));
    end
endmodule

// File: tb/test_lut3_cell.sv
`timescale 1ns/100ps
module test_lut3_cell;
    import lut3_pkg::*;

    typedef struct {
        logic [N_OUT-1:0] nbr;
        logic [N_SEG-1:0] segd;
        logic [N_SEG-1:0] segoe;
        string            tag;
    } item_t;

    logic                   clk = 1'b0;
    logic                   clk_b = 1'b0;
    logic                   init = 1'b1;
    cell_cfg_t              cfg = '0;
    logic [N_IN*N_CAND-1:0] cand = '0;
    logic [N_OUT-1:0]       nbr;
    logic [N_SEG-1:0]       segd;
    logic [N_SEG-1:0]       segoe;
    logic                   m_q = 1'b0;
    item_t                  sb[$];
    int                     checks = 0;
    int                     errors = 0;
    bit                     done = 0;

    always #2.5 clk = ~clk;

    lut3_cell i_lut3_cell (
        .clk_a    (clk),
        .clk_b    (clk_b),
        .init_i   (init),
        .cfg_i    (cfg),
        .cand_i   (cand),
        .nbr_o    (nbr),
        .seg_d_o  (segd),
        .seg_oe_o (segoe)
    );

    // Reference model built from the requirements
    function automatic logic wire_of(input int k);
        return cand[k*N_CAND + int'(cfg.in_sel[k])];
    endfunction

    function automatic logic tab(input logic q);
        logic [N_IN-1:0] idx;
        idx = {cfg.fb_on ? q : wire_of(2), wire_of(1), wire_of(0)};
        return cfg.truth[idx];
    endfunction

    task automatic settle();
        logic g;
        g = cfg.clk_b_sel ? clk_b : clk;
        if (init)
            m_q = cfg.init_val;
        else if (g) begin
            m_q = tab(m_q);
            m_q = tab(m_q);
        end
    endtask

    always @(clk or clk_b) begin
        #0.2;
        settle();
    end

    function automatic item_t expect_of(input string tag);
        item_t it;
        logic  res;
        res = cfg.bypass ? tab(m_q) : m_q;
        for (int j = 0; j < N_OUT; j++)
            it.nbr[j] = (cfg.out_sel[j] == OM_RESULT) ? res : wire_of(int'(cfg.out_sel[j]) - 1);
        for (int k = 0; k < N_SEG; k++) begin
            it.segoe[k] = cfg.seg_en[k];
            it.segd[k]  = cfg.seg_en[k] & res;
        end
        it.tag = tag;
        return it;
    endfunction

    // Driver: apply stimulus in a chosen clock phase, push the expectation
    task automatic step(input bit hi, input cell_cfg_t c, input logic [N_IN*N_CAND-1:0] cd,
                        input logic cb, input logic in, input string tag);
        if (hi) @(posedge clk); else @(negedge clk);
        #0.5;
        cfg = c; cand = cd; clk_b = cb; init = in;
        #0.2;
        settle();
        sb.push_back(expect_of(tag));
        wait (sb.size() == 0);
    endtask

    // Monitor: compare the design outputs with the oldest expectation
    initial begin
        forever begin
            wait (sb.size() > 0);
            #0.3;
            checks++;
            if (nbr !== sb[0].nbr || segd !== sb[0].segd || segoe !== sb[0].segoe) begin
                errors++;
                $display("FAIL %s: nbr=%b segd=%b segoe=%b expected nbr=%b segd=%b segoe=%b",
                         sb[0].tag, nbr, segd, segoe, sb[0].nbr, sb[0].segd, sb[0].segoe);
            end
            void'(sb.pop_front());
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cell_cfg_t c;
        logic [N_IN*N_CAND-1:0] cd;

        // R7 reset state: forced to 1, all outputs show the result
        c = '0; c.init_val = 1'b1; c.seg_en = 2'b11;
        step(1, c, '0, 1'b0, 1'b1, "R7 forced value while init high");
        step(0, c, '0, 1'b0, 1'b0, "R7 value held after init release");
        step(1, c, '0, 1'b0, 1'b0, "R5 open latch loads table zero");

        // R1: selector picks a single candidate wire, table y = A
        c = '0; c.bypass = 1'b1; c.truth = 8'hAA; c.seg_en = 2'b11;
        c.in_sel[0] = 2'd2;
        step(0, c, 12'h004, 1'b0, 1'b0, "R1 select candidate 2 of input A");
        c.in_sel[0] = 2'd1;
        step(0, c, 12'h004, 1'b0, 1'b0, "R1 select candidate 1 of input A");
        c = '0; c.bypass = 1'b1; c.truth = 8'hF0; c.in_sel[2] = 2'd3; c.seg_en = 2'b11;
        step(1, c, 12'h800, 1'b0, 1'b0, "R1 select candidate 3 of input C");

        // R2 and R3: odd-parity table over several patterns in both phases
        for (int i = 0; i < 8; i++) begin
            c = '0; c.bypass = 1'b1; c.truth = 8'h96; c.seg_en = 2'b11;
            c.in_sel[0] = 2'(i); c.in_sel[1] = 2'(i + 1); c.in_sel[2] = 2'(i + 3);
            cd = 12'hA5C ^ 12'(i * 12'h137);
            step(i[0], c, cd, 1'b0, 1'b0, "R2 parity table pattern");
        end
        c = '0; c.bypass = 1'b1; c.clk_b_sel = 1'b1; c.truth = 8'h01; c.seg_en = 2'b11;
        step(0, c, 12'h000, 1'b0, 1'b0, "R3 bypass follows table with clocks low");

        // R5 and R6 on clk_a
        c = '0; c.truth = 8'hAA; c.seg_en = 2'b11;
        step(1, c, 12'h001, 1'b0, 1'b0, "R5 open latch follows A=1");
        step(1, c, 12'h000, 1'b0, 1'b0, "R5 open latch follows A=0");
        step(0, c, 12'h001, 1'b0, 1'b0, "R6 closed latch ignores A=1");
        step(1, c, 12'h001, 1'b0, 1'b0, "R5 latch opens and loads A=1");

        // R4: clk_b picked, clk_a has no effect
        c.clk_b_sel = 1'b1;
        step(1, c, 12'h000, 1'b0, 1'b0, "R4 clk_a high ignored when clk_b picked");
        step(0, c, 12'h000, 1'b1, 1'b0, "R4 clk_b high opens latch");
        step(1, c, 12'h001, 1'b0, 1'b0, "R6 clk_b low holds value");

        // R7 during an open latch
        c.init_val = 1'b0;
        step(1, c, 12'h001, 1'b1, 1'b1, "R7 init overrides open latch");
        step(0, c, 12'h001, 1'b0, 1'b1, "R7 init holds with clock low");
        step(0, c, 12'h001, 1'b0, 1'b0, "R7 forced value held after release");

        // R8: majority of A, B and stored value
        c = '0; c.truth = 8'hE8; c.fb_on = 1'b1; c.clk_b_sel = 1'b1; c.seg_en = 2'b11;
        step(0, c, 12'h011, 1'b1, 1'b0, "R8 A=1 B=1 sets state");
        step(1, c, 12'h001, 1'b1, 1'b0, "R8 A=1 B=0 keeps state 1");
        step(0, c, 12'h000, 1'b1, 1'b0, "R8 A=0 B=0 clears state");
        step(1, c, 12'h010, 1'b1, 1'b0, "R8 A=0 B=1 keeps state 0");
        step(0, c, 12'h011, 1'b1, 1'b0, "R8 A=1 B=1 sets state again");

        // R9: feed-through codes
        c = '0; c.bypass = 1'b1; c.truth = 8'h00; c.seg_en = 2'b11;
        c.out_sel[0] = OM_PASS_A; c.out_sel[1] = OM_PASS_B; c.out_sel[2] = OM_PASS_C;
        step(0, c, 12'h101, 1'b0, 1'b0, "R9 pass A=1 B=0 C=1");
        step(1, c, 12'h110, 1'b0, 1'b0, "R9 pass A=0 B=1 C=1");
        c.fb_on = 1'b1; c.out_sel[0] = OM_RESULT; c.truth = 8'hFF;
        step(0, c, 12'h000, 1'b0, 1'b0, "R9 pass C shows wire under feedback");

        // R10: channel drivers
        c = '0; c.bypass = 1'b1; c.truth = 8'hFF; c.seg_en = 2'b01;
        step(0, c, 12'h000, 1'b0, 1'b0, "R10 driver 0 on, driver 1 off");
        c.seg_en = 2'b10;
        step(1, c, 12'h000, 1'b0, 1'b0, "R10 driver 1 on, driver 0 off");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule